// File: doc/BRIEF.md
# Interrupt Line Configuration Register Bank

This block stores the per-line settings that an interrupt arbiter needs. Each line has an enable bit, an active bit, an 8-bit priority, an 8-bit CPU target mask and a 2-bit trigger field. Software reaches all of this through a plain 32-bit register bus with byte lanes. The block also holds a single global forwarding switch. A read-only word reports how many lines exist, as a count of 32-line groups minus one. The stored vectors go straight out as wide ports to the arbitration logic.

Enable and active bits cannot be written directly. Each has a set alias and a clear alias. A one written into a bit of an alias changes only that line; a zero leaves it alone. Because of this, software never needs a read-modify-write to change one line. Priority and target bytes are addressed by line number, four to a word. Trigger pairs are packed sixteen to a word.

A read returns its data one cycle after the request. Addresses that map to no implemented line, and addresses outside every region, read as zero and ignore writes.

Top module: `irq_cfg_bank`

## Requirements
- R1: After reset, every enable, active, priority, target and trigger bit is zero, the forwarding switch is off, and `bus_rdata` is zero.
- R2: Word w of the set-enable alias is at byte 0x100+4w. A write with bit b set (and its byte lane enabled) sets the enable of line 32w+b. Zero bits have no effect. A read returns the current enables of that word.
- R3: Word w of the clear-enable alias is at byte 0x180+4w. A write with bit b set clears the enable of line 32w+b. Zero bits have no effect. A read returns the current enables.
- R4: The active bits behave the same way as the enables. The set alias is at 0x200+4w and the clear alias is at 0x280+4w. Both read the current active state.
- R5: The priority of line n is the byte at address 0x400+n, in byte lane n%4 of its word. It appears on `irq_prio_o[8n+7:8n]`.
- R6: The target mask of line n is the byte at address 0x800+n, in lane n%4. It appears on `irq_tgt_o[8n+7:8n]`.
- R7: The trigger pair of line n occupies bits [2(n%16)+1 : 2(n%16)] of the word at 0xC00+4(n/16). It appears on `irq_trig_o[2n+1:2n]`. The upper bit of the pair selects edge triggering (1) or level triggering (0), and `irq_edge_o[n]` shows it.
- R8: Bit 0 of the control word at 0x000 is the forwarding switch on `fwd_en_o`. Writing 1 turns it on and writing 0 turns it off. All other control bits read zero.
- R9: The type word at 0x004 reads NUM_LINES/32-1 in bits [4:0] and zero elsewhere. Writes to it are ignored.
- R10: Lines at or above NUM_LINES, and lines 1020 and higher, read zero and ignore writes. The same holds for every address outside the listed regions.
- R11: Read data and `bus_rvalid` appear in the cycle after a read request. `bus_rvalid` is never high in the cycle after a write or an idle cycle.
- R12: A byte lane with its byte enable low is left unchanged by a write. This applies to every writable register and to the set and clear aliases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 12 | Byte address; bits [1:0] are ignored |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte lane enables for writes |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | High one cycle after a read request |
| fwd_en_o | output | 1 | Global forwarding switch |
| irq_en_o | output | NUM_LINES | Enable per line |
| irq_act_o | output | NUM_LINES | Active state per line |
| irq_prio_o | output | 8*NUM_LINES | Priority byte per line |
| irq_tgt_o | output | 8*NUM_LINES | CPU target mask per line |
| irq_trig_o | output | 2*NUM_LINES | Trigger pair per line |
| irq_edge_o | output | NUM_LINES | Edge select per line (upper bit of the trigger pair) |

## Verification
The assertions assume that each request lasts one cycle and that the bus inputs are known whenever reset is released. They do not assume any alignment, because address bits [1:0] are ignored. The alias properties compare the enable vector only against its own previous value. For that reason they hold whatever data and byte-lane pattern is written. The bench drives `bus_req` for exactly one cycle per access and holds it low between accesses. It draws addresses from every region, including word indices past the implemented lines and gaps between regions, so the assumptions are met while the out-of-range paths are still exercised.

// File: rtl/irq_cfg_pkg.sv
package irq_cfg_pkg;

  localparam int unsigned LINE_CAP = 1020;

  typedef enum logic [3:0] {
    RG_NONE, RG_CTRL, RG_TYPE, RG_EN_SET, RG_EN_CLR,
    RG_ACT_SET, RG_ACT_CLR, RG_PRIO, RG_TGT, RG_TRIG
  } reg_region_e;

  // Lines that are actually usable.
  function automatic int unsigned impl_lines(int unsigned n);
    return (n > LINE_CAP) ? LINE_CAP : n;
  endfunction

  // Type field: number of 32-line groups minus one.
  function automatic logic [4:0] type_field(int unsigned n);
    return 5'((n + 31) / 32 - 1);
  endfunction

  function automatic logic [31:0] lane_mask(logic [3:0] be);
    return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
  endfunction

  // Bits b with base+b below limit.
  function automatic logic [31:0] bits_below(int unsigned limit, int unsigned base);
    logic [31:0] m;
    for (int b = 0; b < 32; b++) m[b] = ((base + b) < limit);
    return m;
  endfunction

  // Byte lanes k with base+k below limit, expanded to bits.
  function automatic logic [31:0] bytes_below(int unsigned limit, int unsigned base);
    logic [3:0] v;
    for (int k = 0; k < 4; k++) v[k] = ((base + k) < limit);
    return lane_mask(v);
  endfunction

  function automatic reg_region_e decode_region(logic [11:0] a);
    reg_region_e r;
    unique case (a[11:8])
      4'h0: begin
        if (a[7:2] == 6'd0)      r = RG_CTRL;
        else if (a[7:2] == 6'd1) r = RG_TYPE;
        else                     r = RG_NONE;
      end
      4'h1: r = a[7] ? RG_EN_CLR : RG_EN_SET;
      4'h2: r = a[7] ? RG_ACT_CLR : RG_ACT_SET;
      4'h4, 4'h5, 4'h6, 4'h7: r = RG_PRIO;
      4'h8, 4'h9, 4'hA, 4'hB: r = RG_TGT;
      4'hC: r = RG_TRIG;
      default: r = RG_NONE;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/irq_cfg_decode.sv
module irq_cfg_decode
  import irq_cfg_pkg::*;
(
  input  logic        req_i,
  input  logic        we_i,
  input  logic [11:0] addr_i,
  output reg_region_e region_o,
  output logic        wr_o,
  output logic        rd_o
);
  assign region_o = decode_region(addr_i);
  assign wr_o     = req_i & we_i;
  assign rd_o     = req_i & ~we_i;
endmodule

// File: rtl/irq_bitvec.sv
module irq_bitvec
  import irq_cfg_pkg::*;
#(
  parameter int unsigned NBITS = 64,
  parameter int unsigned LIMIT = 64,
  parameter int unsigned IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_i,
  input  logic             clr_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [31:0]      wdata_i,
  input  logic [3:0]       be_i,
  output logic [NBITS-1:0] bits_o,
  output logic [31:0]      rword_o
);
  localparam int unsigned NWORDS = NBITS / 32;

  logic [31:0] lanes;
  assign lanes = lane_mask(be_i);

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    localparam logic [31:0] VALID = bits_below(LIMIT, w * 32);
    logic        hit;
    logic [31:0] word_q;
    assign hit = (32'(idx_i) == w);
    always_ff @(posedge clk) begin
      if (!rst_n)              word_q <= '0;
      else if (set_i && hit)   word_q <= word_q | (wdata_i & lanes & VALID);
      else if (clr_i && hit)   word_q <= word_q & ~(wdata_i & lanes & VALID);
    end
    assign bits_o[w*32 +: 32] = word_q;
  end

  always_comb begin
    rword_o = '0;
    for (int w = 0; w < int'(NWORDS); w++)
      if (32'(idx_i) == w) rword_o = bits_o[w*32 +: 32];
  end
endmodule

// File: rtl/irq_byte_array.sv
module irq_byte_array
  import irq_cfg_pkg::*;
#(
  parameter int unsigned NBYTES = 64,
  parameter int unsigned LIMIT  = 64,
  parameter int unsigned IDX_W  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_i,
  input  logic [IDX_W-1:0]    idx_i,
  input  logic [31:0]         wdata_i,
  input  logic [3:0]          be_i,
  output logic [8*NBYTES-1:0] bytes_o,
  output logic [31:0]         rword_o
);
  localparam int unsigned NWORDS = NBYTES / 4;

  logic [31:0] lanes;
  assign lanes = lane_mask(be_i);

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    localparam logic [31:0] VALID = bytes_below(LIMIT, w * 4);
    logic        hit;
    logic [31:0] wmask;
    logic [31:0] word_q;
    assign hit   = (32'(idx_i) == w);
    assign wmask = lanes & VALID;
    always_ff @(posedge clk) begin
      if (!rst_n)            word_q <= '0;
      else if (wr_i && hit)  word_q <= (word_q & ~wmask) | (wdata_i & wmask);
    end
    assign bytes_o[w*32 +: 32] = word_q;
  end

  always_comb begin
    rword_o = '0;
    for (int w = 0; w < int'(NWORDS); w++)
      if (32'(idx_i) == w) rword_o = bytes_o[w*32 +: 32];
  end
endmodule

// File: rtl/irq_cfg_bank.sv
module irq_cfg_bank
  import irq_cfg_pkg::*;
#(
  parameter int unsigned NUM_LINES = 64
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_req,
  input  logic                   bus_we,
  input  logic [11:0]            bus_addr,
  input  logic [31:0]            bus_wdata,
  input  logic [3:0]             bus_be,
  output logic [31:0]            bus_rdata,
  output logic                   bus_rvalid,
  output logic                   fwd_en_o,
  output logic [NUM_LINES-1:0]   irq_en_o,
  output logic [NUM_LINES-1:0]   irq_act_o,
  output logic [8*NUM_LINES-1:0] irq_prio_o,
  output logic [8*NUM_LINES-1:0] irq_tgt_o,
  output logic [2*NUM_LINES-1:0] irq_trig_o,
  output logic [NUM_LINES-1:0]   irq_edge_o
);
  localparam int unsigned IMPL       = impl_lines(NUM_LINES);
  localparam logic [4:0]  TYPE_F     = type_field(NUM_LINES);
  localparam int unsigned TRIG_BYTES = NUM_LINES / 4;
  localparam int unsigned TRIG_LIMIT = IMPL / 4;

  // Named events for the checker
  reg_region_e region;
  logic wr_fire, rd_fire;
  logic wr_en_set, wr_en_clr, wr_act_set, wr_act_clr;
  logic wr_prio, wr_tgt, wr_trig, wr_ctrl, wr_inert, rd_type;

  irq_cfg_decode u_dec (
    .req_i   (bus_req),
    .we_i    (bus_we),
    .addr_i  (bus_addr),
    .region_o(region),
    .wr_o    (wr_fire),
    .rd_o    (rd_fire)
  );

  assign wr_en_set  = wr_fire && (region == RG_EN_SET);
  assign wr_en_clr  = wr_fire && (region == RG_EN_CLR);
  assign wr_act_set = wr_fire && (region == RG_ACT_SET);
  assign wr_act_clr = wr_fire && (region == RG_ACT_CLR);
  assign wr_prio    = wr_fire && (region == RG_PRIO);
  assign wr_tgt     = wr_fire && (region == RG_TGT);
  assign wr_trig    = wr_fire && (region == RG_TRIG);
  assign wr_ctrl    = wr_fire && (region == RG_CTRL);
  assign wr_inert   = wr_fire && ((region == RG_NONE) || (region == RG_TYPE));
  assign rd_type    = rd_fire && (region == RG_TYPE);

  logic [31:0] en_rword, act_rword, prio_rword, tgt_rword, trig_rword;

  irq_bitvec #(.NBITS(NUM_LINES), .LIMIT(IMPL), .IDX_W(5)) u_en (
    .clk(clk), .rst_n(rst_n), .set_i(wr_en_set), .clr_i(wr_en_clr),
    .idx_i(bus_addr[6:2]), .wdata_i(bus_wdata), .be_i(bus_be),
    .bits_o(irq_en_o), .rword_o(en_rword)
  );

  irq_bitvec #(.NBITS(NUM_LINES), .LIMIT(IMPL), .IDX_W(5)) u_act (
    .clk(clk), .rst_n(rst_n), .set_i(wr_act_set), .clr_i(wr_act_clr),
    .idx_i(bus_addr[6:2]), .wdata_i(bus_wdata), .be_i(bus_be),
    .bits_o(irq_act_o), .rword_o(act_rword)
  );

  irq_byte_array #(.NBYTES(NUM_LINES), .LIMIT(IMPL), .IDX_W(8)) u_prio (
    .clk(clk), .rst_n(rst_n), .wr_i(wr_prio), .idx_i(bus_addr[9:2]),
    .wdata_i(bus_wdata), .be_i(bus_be), .bytes_o(irq_prio_o), .rword_o(prio_rword)
  );

  irq_byte_array #(.NBYTES(NUM_LINES), .LIMIT(IMPL), .IDX_W(8)) u_tgt (
    .clk(clk), .rst_n(rst_n), .wr_i(wr_tgt), .idx_i(bus_addr[9:2]),
    .wdata_i(bus_wdata), .be_i(bus_be), .bytes_o(irq_tgt_o), .rword_o(tgt_rword)
  );

  irq_byte_array #(.NBYTES(TRIG_BYTES), .LIMIT(TRIG_LIMIT), .IDX_W(6)) u_trig (
    .clk(clk), .rst_n(rst_n), .wr_i(wr_trig), .idx_i(bus_addr[7:2]),
    .wdata_i(bus_wdata), .be_i(bus_be), .bytes_o(irq_trig_o), .rword_o(trig_rword)
  );

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_edge
    assign irq_edge_o[n] = irq_trig_o[2*n+1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                 fwd_en_o <= 1'b0;
    else if (wr_ctrl && bus_be[0]) fwd_en_o <= bus_wdata[0];
  end

  logic [31:0] rmux;
  always_comb begin
    unique case (region)
      RG_CTRL:                rmux = {31'b0, fwd_en_o};
      RG_TYPE:                rmux = {27'b0, TYPE_F};
      RG_EN_SET, RG_EN_CLR:   rmux = en_rword;
      RG_ACT_SET, RG_ACT_CLR: rmux = act_rword;
      RG_PRIO:                rmux = prio_rword;
      RG_TGT:                 rmux = tgt_rword;
      RG_TRIG:                rmux = trig_rword;
      default:                rmux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= rd_fire;
      if (rd_fire) bus_rdata <= rmux;
    end
  end
endmodule

// File: rtl/irq_cfg_bank_chk.sv
module irq_cfg_bank_chk
  import irq_cfg_pkg::*;
#(
  parameter int unsigned NUM_LINES = 64
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   rd_fire,
  input logic                   rd_type,
  input logic                   wr_en_set,
  input logic                   wr_en_clr,
  input logic                   wr_act_clr,
  input logic                   wr_inert,
  input logic [31:0]            bus_rdata,
  input logic                   bus_rvalid,
  input logic                   fwd_en_o,
  input logic [NUM_LINES-1:0]   irq_en_o,
  input logic [NUM_LINES-1:0]   irq_act_o,
  input logic [8*NUM_LINES-1:0] irq_prio_o,
  input logic [8*NUM_LINES-1:0] irq_tgt_o,
  input logic [2*NUM_LINES-1:0] irq_trig_o
);
  localparam logic [4:0] TYPE_F = type_field(NUM_LINES);

  AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (irq_en_o == '0 && irq_act_o == '0 && irq_prio_o == '0 && !fwd_en_o && bus_rdata == '0)); // R1

  AST_SET_NEVER_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_set |=> ((irq_en_o & $past(irq_en_o)) == $past(irq_en_o))); // R2

  AST_CLR_NEVER_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_clr |=> ((irq_en_o | $past(irq_en_o)) == $past(irq_en_o))); // R3

  AST_ACT_CLR_NEVER_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_act_clr |=> ((irq_act_o | $past(irq_act_o)) == $past(irq_act_o))); // R4

  AST_TYPE_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    rd_type |=> (bus_rdata == {27'b0, TYPE_F})); // R9

  AST_INERT_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_inert |=> ($stable(irq_en_o) && $stable(irq_act_o) && $stable(irq_prio_o)
                  && $stable(irq_tgt_o) && $stable(irq_trig_o) && $stable(fwd_en_o))); // R10

  AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> bus_rvalid); // R11

  AST_NO_SPURIOUS_RVALID: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_fire |=> !bus_rvalid); // R11
endmodule

bind irq_cfg_bank irq_cfg_bank_chk #(.NUM_LINES(NUM_LINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_fire(rd_fire), .rd_type(rd_type),
  .wr_en_set(wr_en_set), .wr_en_clr(wr_en_clr), .wr_act_clr(wr_act_clr),
  .wr_inert(wr_inert), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
  .fwd_en_o(fwd_en_o), .irq_en_o(irq_en_o), .irq_act_o(irq_act_o),
  .irq_prio_o(irq_prio_o), .irq_tgt_o(irq_tgt_o), .irq_trig_o(irq_trig_o)
);

// File: tb/irq_cfg_bank_tb.sv
`timescale 1ns/1ps
module irq_cfg_bank_tb;
  localparam int N = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_req = 1'b0, bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [3:0] bus_be = '0;
  logic [31:0] bus_rdata;
  logic bus_rvalid, fwd_en_o;
  logic [N-1:0] irq_en_o, irq_act_o, irq_edge_o;
  logic [8*N-1:0] irq_prio_o, irq_tgt_o;
  logic [2*N-1:0] irq_trig_o;

  always #2.5 clk = ~clk;

  irq_cfg_bank #(.NUM_LINES(N)) u_dut (.*);

  int vectors = 0, fails = 0;

  // Reference state
  bit en_m[N], act_m[N], fwd_m;
  bit [7:0] prio_m[N], tgt_m[N];
  bit [1:0] trig_m[N];

  task automatic chk(string req, logic [511:0] act, logic [511:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  function automatic logic [31:0] exp_read(int unsigned a);
    int unsigned wa = a & 32'hFFC;
    logic [31:0] r = '0;
    if (wa == 0) r[0] = fwd_m;
    else if (wa == 4) r[4:0] = 5'(N / 32 - 1);
    else if (wa >= 'h100 && wa < 'h300) begin
      int unsigned w = ((wa - 'h100) / 4) % 32;
      for (int b = 0; b < 32; b++)
        if (w * 32 + b < N) r[b] = (wa < 'h200) ? en_m[w*32+b] : act_m[w*32+b];
    end else if (wa >= 'h400 && wa < 'hC00) begin
      int unsigned first = (wa - 'h400) % 'h400;
      for (int k = 0; k < 4; k++)
        if (first + k < N) r[8*k +: 8] = (wa < 'h800) ? prio_m[first+k] : tgt_m[first+k];
    end else if (wa >= 'hC00 && wa < 'hD00) begin
      int unsigned q = (wa - 'hC00) / 4;
      for (int j = 0; j < 16; j++)
        if (q * 16 + j < N) r[2*j +: 2] = trig_m[q*16+j];
    end
    return r;
  endfunction

  task automatic model_write(int unsigned a, logic [31:0] d, logic [3:0] be);
    int unsigned wa = a & 32'hFFC;
    if (wa == 0) begin
      if (be[0]) fwd_m = d[0];
    end else if (wa >= 'h100 && wa < 'h300) begin
      int unsigned w = ((wa - 'h100) / 4) % 32;
      bit setop = (((wa - 'h100) / 'h80) % 2) == 0;
      for (int b = 0; b < 32; b++)
        if (be[b/8] && d[b] && w * 32 + b < N) begin
          if (wa < 'h200) en_m[w*32+b] = setop;
          else            act_m[w*32+b] = setop;
        end
    end else if (wa >= 'h400 && wa < 'hC00) begin
      int unsigned first = (wa - 'h400) % 'h400;
      for (int k = 0; k < 4; k++)
        if (be[k] && first + k < N) begin
          if (wa < 'h800) prio_m[first+k] = d[8*k +: 8];
          else            tgt_m[first+k]  = d[8*k +: 8];
        end
    end else if (wa >= 'hC00 && wa < 'hD00) begin
      int unsigned q = (wa - 'hC00) / 4;
      for (int j = 0; j < 16; j++)
        if (be[j/4] && q * 16 + j < N) trig_m[q*16+j] = d[2*j +: 2];
    end
  endtask

  task automatic check_outputs(string req);
    logic [511:0] e_en = '0, e_act = '0, e_pr = '0, e_tg = '0, e_tr = '0, e_ed = '0;
    for (int n = 0; n < N; n++) begin
      e_en[n] = en_m[n]; e_act[n] = act_m[n];
      e_pr[8*n +: 8] = prio_m[n]; e_tg[8*n +: 8] = tgt_m[n];
      e_tr[2*n +: 2] = trig_m[n]; e_ed[n] = trig_m[n][1];
    end
    chk({req, " en"},   512'(irq_en_o),   e_en);
    chk({req, " act"},  512'(irq_act_o),  e_act);
    chk({req, " prio"}, 512'(irq_prio_o), e_pr);
    chk({req, " tgt"},  512'(irq_tgt_o),  e_tg);
    chk({req, " trig"}, 512'(irq_trig_o), e_tr);
    chk({req, " edge R7"}, 512'(irq_edge_o), e_ed);
    chk({req, " fwd"},  512'(fwd_en_o),   512'(fwd_m));
  endtask

  task automatic bus_write(int unsigned a, logic [31:0] d, logic [3:0] be, string req);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = 12'(a); bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
    model_write(a, d, be);
    chk({req, " R11 no rvalid on write"}, 512'(bus_rvalid), 512'(0));
    check_outputs(req);
  endtask

  task automatic bus_read(int unsigned a, string req);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = 12'(a);
    @(negedge clk);
    bus_req = 1'b0;
    chk({req, " R11 rvalid"}, 512'(bus_rvalid), 512'(1));
    chk(req, 512'(bus_rdata), 512'(exp_read(a)));
  endtask

  initial begin
    void'($urandom(32'd1234));
    fwd_m = 0;
    for (int n = 0; n < N; n++) begin
      en_m[n] = 0; act_m[n] = 0; prio_m[n] = 0; tgt_m[n] = 0; trig_m[n] = 0;
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check_outputs("R1 reset");
    chk("R1 rdata reset", 512'(bus_rdata), 512'(0));
    bus_read('h000, "R1 ctrl read");
    bus_read('h104, "R1 enable read");
    // R8: forwarding switch
    bus_write('h000, 32'hFFFF_FFFF, 4'hF, "R8 fwd on");
    bus_read('h000, "R8 ctrl read on");
    bus_write('h000, 32'h0, 4'hF, "R8 fwd off");
    // R9: type register, read only
    bus_read('h004, "R9 type");
    bus_write('h004, 32'hFFFF_FFFF, 4'hF, "R9 type write ignored");
    bus_read('h004, "R9 type after write");
    // R2 / R3: set and clear aliases
    bus_write('h100, 32'h0000_8001, 4'hF, "R2 set en");
    bus_write('h100, 32'h0, 4'hF, "R2 zero no effect");
    bus_write('h104, 32'h8000_0000, 4'hF, "R2 set en line 63");
    bus_read('h100, "R2 read set alias");
    bus_write('h180, 32'h0000_0001, 4'hF, "R3 clear en");
    bus_read('h180, "R3 read clear alias");
    bus_write('h180, 32'h0, 4'hF, "R3 zero no effect");
    // R12: byte lanes on an alias
    bus_write('h100, 32'hFFFF_FFFF, 4'b0010, "R12 set en lane1");
    bus_write('h184, 32'hFFFF_FFFF, 4'b1000, "R12 clear en lane3");
    // R4: active aliases
    bus_write('h204, 32'h0F0F_0000, 4'hF, "R4 set act");
    bus_write('h284, 32'h0101_0000, 4'hF, "R4 clear act");
    bus_read('h284, "R4 read clear act");
    // R5 / R12: priority bytes
    bus_write('h404, 32'hA1B2_C3D4, 4'b0101, "R5 prio lanes 0,2");
    bus_read('h404, "R5 prio read");
    bus_write('h43C, 32'h1234_5678, 4'hF, "R5 prio last word");
    // R6: target bytes
    bus_write('h808, 32'h0102_0408, 4'hF, "R6 tgt");
    bus_read('h808, "R6 tgt read");
    // R7: trigger pairs
    bus_write('hC00, 32'h8000_0002, 4'hF, "R7 edge lines 0,15");
    bus_write('hC0C, 32'hAAAA_AAAA, 4'b1100, "R7 upper lanes");
    bus_read('hC00, "R7 trig read");
    // R10: out of range and unmapped
    bus_write('h108, 32'hFFFF_FFFF, 4'hF, "R10 en word beyond lines");
    bus_read('h108, "R10 en beyond read");
    bus_write('h500, 32'hFFFF_FFFF, 4'hF, "R10 prio beyond lines");
    bus_read('h500, "R10 prio beyond read");
    bus_write('hC10, 32'hFFFF_FFFF, 4'hF, "R10 trig beyond lines");
    bus_write('hF00, 32'hFFFF_FFFF, 4'hF, "R10 unmapped write");
    bus_read('hF00, "R10 unmapped read");
    bus_read('h008, "R10 ctrl gap read");
    // Random mix across all regions
    for (int i = 0; i < 3000; i++) begin
      int unsigned a;
      logic [31:0] d = $urandom;
      logic [3:0] be = ($urandom_range(0, 3) == 0) ? 4'($urandom) : 4'hF;
      case ($urandom_range(0, 8))
        0: a = 4 * $urandom_range(0, 3);
        1: a = 'h100 + 4 * $urandom_range(0, 3);
        2: a = 'h180 + 4 * $urandom_range(0, 3);
        3: a = 'h200 + 4 * $urandom_range(0, 3);
        4: a = 'h280 + 4 * $urandom_range(0, 3);
        5: a = 'h400 + 4 * $urandom_range(0, 19);
        6: a = 'h800 + 4 * $urandom_range(0, 19);
        7: a = 'hC00 + 4 * $urandom_range(0, 5);
        default: a = 'hD00 + 4 * $urandom_range(0, 191);
      endcase
      a = a | $urandom_range(0, 3);
      if ($urandom_range(0, 1) == 0) bus_write(a, d, be, "R12 random write");
      else                           bus_read(a, "R2 random read");
    end
    finish_run();
  end
endmodule